// File: doc/BRIEF.md
# Low-Power Mode Wake Controller

This block tracks the power state of a processor core and decides when the core halts and when it resumes. It has four states. Run (code 0) is normal operation. Idle (code 1) halts the core but leaves the system clock running. Sleep (code 2) gates every clock. Start (code 3) is a transient wait for an oscillator to settle after Sleep. A wait strobe from the core requests a low-power state. The sleep-enable bit decides whether that state is Idle or Sleep.

Three kinds of event can wake the core: an enabled interrupt, a reset request and a watchdog time-out. An interrupt resumes the core only if its priority is strictly above the current core priority. In Sleep, a lower-priority or equal-priority interrupt does not resume the core, but it restarts the peripheral clock and moves the block to Idle. In Idle, each peripheral can be gated on its own through a stop-in-idle mask. The cause of each wake is latched in a sticky flag that software clears. When the clock source uses a crystal or PLL, waking from Sleep inserts a programmable start-up delay.

Transitions are named as follows:
- Run→Idle: enter_idle.
- Run→Sleep: enter_sleep.
- Idle→Run: idle_wake.
- Sleep→Run: sleep_wake.
- Sleep→Start: sleep_wake_slow.
- Sleep→Idle: sleep_demote.
- Start→Run: osc_ready.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: With no wake event present, a wait strobe in Run with sleep_en=0 moves the block to Idle (pwr_state=1). In Idle, cpu_clk_en=0, sys_clk_en=1 and pb_clk_en=1.
- R2: With no wake event present, a wait strobe in Run with sleep_en=1 moves the block to Sleep (pwr_state=2). In Sleep, cpu_clk_en, sys_clk_en, pb_clk_en and every periph_clk_en bit are 0.
- R3: An interrupt is a wake event only when irq_valid=1 and irq_prio > cpu_prio (unsigned). An equal or lower priority, or an interrupt with irq_valid=0, never resumes the core from Idle or Sleep.
- R4: In Sleep, a valid interrupt with irq_prio <= cpu_prio moves the block to Idle, provided no other wake event is present. This sets no cause flag.
- R5: In Idle, a valid interrupt with irq_prio <= cpu_prio leaves the block in Idle.
- R6: reset_req or wdt_timeout wakes the block from both Idle and Sleep.
- R7: In Idle, periph_clk_en[i] = ~stop_in_idle[i], and the mask is followed each cycle. In Run, all bits of periph_clk_en are 1.
- R8: Leaving Idle never inserts a delay. A wake from Sleep goes to Start (pwr_state=3) only when osc_needs_start=1 and start_dly=N>0. The block then stays in Start, with all clocks gated, for exactly N cycles before returning to Run. Otherwise it goes straight to Run.
- R9: When a wake takes effect, the cause flags are set: wake_cause[0] for a qualifying interrupt, [1] for reset_req and [2] for wdt_timeout. They stay set until cause_clr=1. A set in the same cycle as cause_clr wins.
- R10: A wake event in the same cycle as the wait strobe keeps the block in Run and latches its cause.
- R11: After rst_n is asserted, the block is in Run, all clock enables are 1 and wake_cause=0.
- R12: In Run without a wait strobe, the wake inputs are ignored: the state and wake_cause do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_strobe | input | 1 | Core executed a wait; request low power |
| sleep_en | input | 1 | 1 selects Sleep, 0 selects Idle |
| cpu_prio | input | PRIO_W | Current core priority |
| irq_valid | input | 1 | An enabled interrupt is pending |
| irq_prio | input | PRIO_W | Priority of the highest pending interrupt |
| reset_req | input | 1 | Reset source request (wake) |
| wdt_timeout | input | 1 | Watchdog time-out (wake) |
| stop_in_idle | input | NUM_PERIPH | Per-peripheral gate-in-Idle mask |
| osc_needs_start | input | 1 | Clock source uses a crystal or PLL |
| start_dly | input | DLY_W | Start-up delay in clock cycles |
| cause_clr | input | 1 | Clear all wake-cause flags |
| cpu_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System clock enable |
| pb_clk_en | output | 1 | Peripheral bus clock enable |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock enables |
| wake_cause | output | 3 | Sticky flags {watchdog, reset, interrupt} |
| pwr_state | output | 2 | Current state code |

## Verification
A wrong state register shows at the ports on the very next cycle. Each state has its own pattern of clock enables, and the state code is also brought out directly. If the priority compare is wrong, an equal-priority interrupt turns into a false wake: one edge later the core clock comes back on and wake_cause[0] is set. Faults in the start-up counter appear only as a Start phase that is too long or too short. These are caught by counting the cycles until cpu_clk_en rises after a slow wake.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_SLEEP = 2'd2,
        ST_START = 2'd3
    } pwr_state_e;

    localparam int CAUSE_W   = 3;
    localparam int CAUSE_IRQ = 0;
    localparam int CAUSE_RST = 1;
    localparam int CAUSE_WDT = 2;
endpackage

// File: rtl/pwr_wake_eval.sv
module pwr_wake_eval #(
    parameter int PRIO_W = 3
) (
    input  logic              irq_valid,
    input  logic [PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0] cpu_prio,
    input  logic              reset_req,
    input  logic              wdt_timeout,
    output logic              irq_wake,
    output logic              irq_low,
    output logic              any_wake
);
    // Interrupt must strictly outrank the core to resume it
    always_comb begin
        irq_wake = irq_valid && (irq_prio > cpu_prio);
        irq_low  = irq_valid && !irq_wake;
        any_wake = irq_wake || reset_req || wdt_timeout;
    end
endmodule

// File: rtl/pwr_osc_timer.sv
module pwr_osc_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             run,
    output logic             done
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - DLY_W'(1);
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pwr_cause_reg.sv
module pwr_cause_reg #(
    parameter int CAUSE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] set_vec,
    input  logic               clr,
    output logic [CAUSE_W-1:0] cause
);
    // Set wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause <= '0;
        end else if (clr) begin
            cause <= set_vec;
        end else begin
            cause <= cause | set_vec;
        end
    end
endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
    import pwr_wake_pkg::*;
#(
    parameter int NUM_PERIPH = 4
) (
    input  pwr_state_e            state,
    input  logic [NUM_PERIPH-1:0] stop_in_idle,
    output logic                  cpu_clk_en,
    output logic                  sys_clk_en,
    output logic                  pb_clk_en,
    output logic [NUM_PERIPH-1:0] periph_clk_en
);
    logic in_idle;

    always_comb begin
        in_idle = 1'b0;
        unique case (state)
            ST_RUN: begin
                cpu_clk_en = 1'b1;
                sys_clk_en = 1'b1;
                pb_clk_en  = 1'b1;
            end
            ST_IDLE: begin
                cpu_clk_en = 1'b0;
                sys_clk_en = 1'b1;
                pb_clk_en  = 1'b1;
                in_idle    = 1'b1;
            end
            ST_SLEEP, ST_START: begin
                cpu_clk_en = 1'b0;
                sys_clk_en = 1'b0;
                pb_clk_en  = 1'b0;
            end
            default: begin
                cpu_clk_en = 1'b0;
                sys_clk_en = 1'b0;
                pb_clk_en  = 1'b0;
            end
        endcase
    end

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_periph
        assign periph_clk_en[i] = pb_clk_en && !(in_idle && stop_in_idle[i]);
    end
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
    import pwr_wake_pkg::*;
#(
    parameter int PRIO_W     = 3,
    parameter int NUM_PERIPH = 4,
    parameter int DLY_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wait_strobe,
    input  logic                  sleep_en,
    input  logic [PRIO_W-1:0]     cpu_prio,
    input  logic                  irq_valid,
    input  logic [PRIO_W-1:0]     irq_prio,
    input  logic                  reset_req,
    input  logic                  wdt_timeout,
    input  logic [NUM_PERIPH-1:0] stop_in_idle,
    input  logic                  osc_needs_start,
    input  logic [DLY_W-1:0]      start_dly,
    input  logic                  cause_clr,
    output logic                  cpu_clk_en,
    output logic                  sys_clk_en,
    output logic                  pb_clk_en,
    output logic [NUM_PERIPH-1:0] periph_clk_en,
    output logic [2:0]            wake_cause,
    output logic [1:0]            pwr_state
);
    pwr_state_e           state_q, state_d;
    logic                 irq_wake, irq_low, any_wake;
    logic                 need_delay, tmr_load, tmr_done, take_wake;
    logic [DLY_W-1:0]     dly_m1;
    logic [CAUSE_W-1:0]   cause_set;

    pwr_wake_eval #(.PRIO_W(PRIO_W)) u_eval (
        .irq_valid   (irq_valid),
        .irq_prio    (irq_prio),
        .cpu_prio    (cpu_prio),
        .reset_req   (reset_req),
        .wdt_timeout (wdt_timeout),
        .irq_wake    (irq_wake),
        .irq_low     (irq_low),
        .any_wake    (any_wake)
    );

    assign need_delay = osc_needs_start && (start_dly != '0);
    assign dly_m1     = start_dly - DLY_W'(1);

    pwr_osc_timer #(.DLY_W(DLY_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (dly_m1),
        .run      (state_q == ST_START),
        .done     (tmr_done)
    );

    // Next-state and transition decode
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        take_wake = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (wait_strobe) begin
                    if (any_wake) begin
                        take_wake = 1'b1;               // wake beats entry
                    end else if (sleep_en) begin
                        state_d = ST_SLEEP;             // enter_sleep
                    end else begin
                        state_d = ST_IDLE;              // enter_idle
                    end
                end
            end
            ST_IDLE: begin
                if (any_wake) begin
                    take_wake = 1'b1;
                    state_d   = ST_RUN;                 // idle_wake
                end
            end
            ST_SLEEP: begin
                if (any_wake) begin
                    take_wake = 1'b1;
                    if (need_delay) begin
                        tmr_load = 1'b1;
                        state_d  = ST_START;            // sleep_wake_slow
                    end else begin
                        state_d  = ST_RUN;              // sleep_wake
                    end
                end else if (irq_low) begin
                    state_d = ST_IDLE;                  // sleep_demote
                end
            end
            ST_START: begin
                if (tmr_done) begin
                    state_d = ST_RUN;                   // osc_ready
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cause_set            = '0;
        cause_set[CAUSE_IRQ] = take_wake && irq_wake;
        cause_set[CAUSE_RST] = take_wake && reset_req;
        cause_set[CAUSE_WDT] = take_wake && wdt_timeout;
    end

    pwr_cause_reg #(.CAUSE_W(CAUSE_W)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (cause_set),
        .clr     (cause_clr),
        .cause   (wake_cause)
    );

    pwr_clk_gate #(.NUM_PERIPH(NUM_PERIPH)) u_gate (
        .state         (state_q),
        .stop_in_idle  (stop_in_idle),
        .cpu_clk_en    (cpu_clk_en),
        .sys_clk_en    (sys_clk_en),
        .pb_clk_en     (pb_clk_en),
        .periph_clk_en (periph_clk_en)
    );

    assign pwr_state = state_q;
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk #(
    parameter int PRIO_W     = 3,
    parameter int NUM_PERIPH = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wait_strobe,
    input logic                  sleep_en,
    input logic [PRIO_W-1:0]     cpu_prio,
    input logic                  irq_valid,
    input logic [PRIO_W-1:0]     irq_prio,
    input logic                  reset_req,
    input logic                  wdt_timeout,
    input logic [NUM_PERIPH-1:0] stop_in_idle,
    input logic                  cause_clr,
    input logic                  cpu_clk_en,
    input logic                  sys_clk_en,
    input logic                  pb_clk_en,
    input logic [NUM_PERIPH-1:0] periph_clk_en,
    input logic [2:0]            wake_cause,
    input logic [1:0]            pwr_state
);
    logic hi_irq, hard, no_wake;
    assign hi_irq  = irq_valid && (irq_prio > cpu_prio);
    assign hard    = reset_req || wdt_timeout;
    assign no_wake = !hi_irq && !hard;

    p_enter_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && wait_strobe && !sleep_en && no_wake) |=> (pwr_state == 2'd1));

    p_sleep_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd2) |-> (!cpu_clk_en && !sys_clk_en && !pb_clk_en && periph_clk_en == '0));

    p_low_irq_no_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd1 && no_wake) |=> (pwr_state == 2'd1));

    p_sleep_demote_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd2 && irq_valid && !hi_irq && !hard) |=> (pwr_state == 2'd1));

    p_hard_wake_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd1 && hard) |=> (pwr_state == 2'd0));

    p_idle_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd1) |-> (periph_clk_en == ~stop_in_idle && sys_clk_en && !cpu_clk_en));

    p_start_from_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 || pwr_state == 2'd1) |=> (pwr_state != 2'd3));

    p_cause_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_clr |=> ((wake_cause & $past(wake_cause)) == $past(wake_cause)));

    p_wake_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && wait_strobe && !no_wake) |=> (pwr_state == 2'd0));

    p_run_ignores_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd0 && !wait_strobe && !cause_clr) |=> (pwr_state == 2'd0 && $stable(wake_cause)));
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk #(.PRIO_W(PRIO_W), .NUM_PERIPH(NUM_PERIPH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wait_strobe   (wait_strobe),
    .sleep_en      (sleep_en),
    .cpu_prio      (cpu_prio),
    .irq_valid     (irq_valid),
    .irq_prio      (irq_prio),
    .reset_req     (reset_req),
    .wdt_timeout   (wdt_timeout),
    .stop_in_idle  (stop_in_idle),
    .cause_clr     (cause_clr),
    .cpu_clk_en    (cpu_clk_en),
    .sys_clk_en    (sys_clk_en),
    .pb_clk_en     (pb_clk_en),
    .periph_clk_en (periph_clk_en),
    .wake_cause    (wake_cause),
    .pwr_state     (pwr_state)
);

// File: tb/pwr_wake_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_wake_ctrl_bench;
    localparam int PRIO_W = 3;
    localparam int NP     = 4;
    localparam int DLY_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wait_strobe = 0, sleep_en = 0, irq_valid = 0, reset_req = 0, wdt_timeout = 0;
    logic cause_clr = 0, osc_needs_start = 0;
    logic [PRIO_W-1:0] cpu_prio = 3'd2, irq_prio = 3'd0;
    logic [NP-1:0] stop_in_idle = 4'b0101;
    logic [DLY_W-1:0] start_dly = 8'd5;
    logic cpu_clk_en, sys_clk_en, pb_clk_en;
    logic [NP-1:0] periph_clk_en;
    logic [2:0] wake_cause;
    logic [1:0] pwr_state;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pwr_wake_ctrl #(.PRIO_W(PRIO_W), .NUM_PERIPH(NP), .DLY_W(DLY_W)) u_pwr_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .wait_strobe(wait_strobe), .sleep_en(sleep_en),
        .cpu_prio(cpu_prio), .irq_valid(irq_valid), .irq_prio(irq_prio),
        .reset_req(reset_req), .wdt_timeout(wdt_timeout), .stop_in_idle(stop_in_idle),
        .osc_needs_start(osc_needs_start), .start_dly(start_dly), .cause_clr(cause_clr),
        .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en), .pb_clk_en(pb_clk_en),
        .periph_clk_en(periph_clk_en), .wake_cause(wake_cause), .pwr_state(pwr_state)
    );

    // Vector: {ws, se, cpu_prio[3], iv, irq_prio[3], rst, wdt, clr, exp_state[2], exp_cause[3]}
    localparam int NV = 20;
    localparam logic [16:0] VEC [NV] = '{
        {1'b1,1'b0,3'd2,1'b0,3'd0,1'b0,1'b0,1'b0,2'd1,3'b000}, // R1 enter idle
        {1'b0,1'b0,3'd2,1'b1,3'd2,1'b0,1'b0,1'b0,2'd1,3'b000}, // R5 equal prio
        {1'b0,1'b0,3'd2,1'b1,3'd1,1'b0,1'b0,1'b0,2'd1,3'b000}, // R5 lower prio
        {1'b0,1'b0,3'd2,1'b1,3'd3,1'b0,1'b0,1'b0,2'd0,3'b001}, // R3 higher wakes
        {1'b0,1'b0,3'd2,1'b0,3'd0,1'b0,1'b0,1'b1,2'd0,3'b000}, // R9 clear
        {1'b1,1'b1,3'd2,1'b0,3'd0,1'b0,1'b0,1'b0,2'd2,3'b000}, // R2 enter sleep
        {1'b0,1'b0,3'd2,1'b1,3'd2,1'b0,1'b0,1'b0,2'd1,3'b000}, // R4 demote
        {1'b0,1'b0,3'd2,1'b0,3'd0,1'b0,1'b1,1'b0,2'd0,3'b100}, // R6 wdt from idle
        {1'b0,1'b0,3'd2,1'b0,3'd0,1'b0,1'b0,1'b1,2'd0,3'b000}, // R9 clear
        {1'b1,1'b1,3'd2,1'b1,3'd5,1'b0,1'b0,1'b0,2'd0,3'b001}, // R10 collision
        {1'b0,1'b0,3'd2,1'b0,3'd0,1'b0,1'b0,1'b1,2'd0,3'b000}, // R9 clear
        {1'b1,1'b1,3'd2,1'b0,3'd0,1'b0,1'b0,1'b0,2'd2,3'b000}, // R2 sleep
        {1'b0,1'b0,3'd2,1'b0,3'd7,1'b0,1'b0,1'b0,2'd2,3'b000}, // R3 invalid irq
        {1'b0,1'b0,3'd2,1'b0,3'd0,1'b1,1'b0,1'b0,2'd0,3'b010}, // R6 reset from sleep
        {1'b0,1'b0,3'd2,1'b0,3'd0,1'b0,1'b0,1'b1,2'd0,3'b000}, // R9 clear
        {1'b1,1'b0,3'd7,1'b1,3'd7,1'b0,1'b0,1'b0,2'd1,3'b000}, // R3 equal max prio
        {1'b0,1'b0,3'd7,1'b0,3'd0,1'b1,1'b0,1'b1,2'd0,3'b010}, // R9 set wins
        {1'b0,1'b0,3'd2,1'b1,3'd6,1'b0,1'b0,1'b0,2'd0,3'b010}, // R12 irq in run
        {1'b0,1'b0,3'd2,1'b0,3'd0,1'b0,1'b1,1'b0,2'd0,3'b010}, // R12 wdt in run
        {1'b0,1'b0,3'd2,1'b0,3'd0,1'b0,1'b0,1'b1,2'd0,3'b000}  // R9 clear
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_clk(input logic [1:0] st, input logic [NP-1:0] stop);
        case (st)
            2'd0:    exp_clk = {3'b111, {NP{1'b1}}};
            2'd1:    exp_clk = {3'b011, ~stop};
            default: exp_clk = 7'b0;
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        wait_strobe = 0; sleep_en = 0; irq_valid = 0; irq_prio = 0;
        reset_req = 0; wdt_timeout = 0; cause_clr = 0; cpu_prio = 3'd2;
    endtask

    task automatic check_all(input string req, input logic [1:0] st, input logic [2:0] cause);
        check(req, "state", 32'(pwr_state), 32'(st));
        check(req, "cause", 32'(wake_cause), 32'(cause));
        check(req, "clocks", 32'({cpu_clk_en, sys_clk_en, pb_clk_en, periph_clk_en}),
              32'(exp_clk(st, stop_in_idle)));
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check_all("R11", 2'd0, 3'b000);             // reset state
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            {wait_strobe, sleep_en, cpu_prio, irq_valid, irq_prio,
             reset_req, wdt_timeout, cause_clr} = VEC[i][16:5];
            step();
            check_all($sformatf("vec%0d R1-table", i), VEC[i][4:3], VEC[i][2:0]);
        end
        quiet();

        // R8: slow wake from sleep, start delay of 5 cycles
        osc_needs_start = 1; start_dly = 8'd5;
        wait_strobe = 1; sleep_en = 1; step(); quiet();
        check_all("R8 sleep", 2'd2, 3'b000);
        wdt_timeout = 1; step(); quiet();
        for (int k = 0; k < 5; k++) begin
            check_all("R8 start", 2'd3, 3'b100);
            step();
        end
        check_all("R8 ready", 2'd0, 3'b100);
        cause_clr = 1; step(); quiet();

        // R8: idle exit adds no delay even with a slow oscillator
        wait_strobe = 1; step(); quiet();
        check_all("R8 idle", 2'd1, 3'b000);
        irq_valid = 1; irq_prio = 3'd3; step(); quiet();
        check_all("R8 idle exit fast", 2'd0, 3'b001);
        cause_clr = 1; step(); quiet();

        // R8: zero delay goes straight to run
        start_dly = 8'd0;
        wait_strobe = 1; sleep_en = 1; step(); quiet();
        reset_req = 1; step(); quiet();
        check_all("R8 zero delay", 2'd0, 3'b010);
        cause_clr = 1; step(); quiet();

        // R7: mask changes while idle
        wait_strobe = 1; step(); quiet();
        stop_in_idle = 4'b1100; #1;
        check("R7", "periph", 32'(periph_clk_en), 32'h3);
        stop_in_idle = 4'b0000; #1;
        check("R7", "periph", 32'(periph_clk_en), 32'hF);
        stop_in_idle = 4'b0101;

        // R11: reset while sleeping
        wdt_timeout = 1; step(); quiet();
        wait_strobe = 1; sleep_en = 1; step(); quiet();
        check_all("R2 sleep again", 2'd2, 3'b100);
        rst_n = 1'b0; #1;
        check_all("R11 async reset", 2'd0, 3'b000);
        step();
        rst_n = 1'b1;
        step();
        check_all("R11 after release", 2'd0, 3'b000);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule